// File: doc/BRIEF.md
# Identifier-Matched Associative Crossbar

This block joins N processors through a square grid of associative crosspoints. Each processor owns one write row, on which it places a packet made of an identifier and a data word. It also owns one read column, on which it places the identifier it wishes to receive. A packet is not steered by a destination number. Every crosspoint compares the identifier on its row with the identifier requested on its column, and on equality it passes the packet down that column. The number of crosspoints therefore grows as N squared.

A crosspoint stores nothing except the request currently on its column. A packet must therefore be on its row in the same cycle that the matching request is on the column, or it is lost. A column cannot merge two packets. When two or more valid rows match one column in the same cycle, that column raises a collision flag for one cycle and delivers nothing. Each column's result is registered. A delivery appears one clock after the cycle in which the match occurs, as a one-cycle `out_valid` strobe carrying the requested identifier and the matched data.

The data paths carry a valid bit and no ready signal. The crosspoints hold no storage, so there is nothing to stall: a row is consumed or dropped in the cycle it is offered, and a reader cannot exert back-pressure. Pacing traffic so that readers are ready and collisions are avoided is the job of the code that schedules the processors.

Top module: `assoc_xbar`

## Requirements
- R1: When valid read column c requests identifier X and exactly one valid write row carries identifier X in cycle t, then after the clock edge that ends cycle t, `out_valid[c]` is 1, `out_id` slice c equals X, and `out_data` slice c equals that row's data word.
- R2: A valid read column whose identifier matches no valid write row gives `out_valid[c]`=0, `out_collide[c]`=0 and all-zero id and data slices one clock later.
- R3: A write row with `wr_valid`=0 takes part in no match, whatever its identifier: it delivers nothing and adds to no collision.
- R4: A read column with `rd_valid`=0 produces neither `out_valid` nor `out_collide` one clock later.
- R5: When two or more valid rows match a valid column in one cycle, that column shows `out_collide`=1, `out_valid`=0 and zero data one clock later.
- R6: One packet is delivered in the same cycle to every valid column that requests its identifier (multicast).
- R7: Nothing is stored. A packet offered in a cycle with no matching request is not delivered when the request appears in a later cycle.
- R8: While reset (`rst_n` low, asynchronous) is asserted and after it is released, all `out_valid` and `out_collide` bits are 0 and all id and data slices are 0, until the first match.
- R9: The output id and data slices are zero whenever `out_valid` for that column is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | N | Row r offers a packet this cycle |
| wr_id | input | N*ID_W | Packet identifier of row r at bits [r*ID_W +: ID_W] |
| wr_data | input | N*DATA_W | Packet data of row r at bits [r*DATA_W +: DATA_W] |
| rd_valid | input | N | Column c requests this cycle |
| rd_id | input | N*ID_W | Requested identifier of column c at bits [c*ID_W +: ID_W] |
| out_valid | output | N | Column c delivered a packet (registered, one clock later) |
| out_id | output | N*ID_W | Delivered identifier of column c |
| out_data | output | N*DATA_W | Delivered data of column c |
| out_collide | output | N | Column c saw two or more matching rows |

## Verification
The bench builds the crossbar with four ports, 4-bit identifiers and 8-bit data. With these values every row of a column can match at once, which exercises collisions of two, three and four rows. The bench also draws random identifiers from a range of only four values, so multicast, collision and no-match cases all occur many times in a random run. A small port count keeps every crosspoint reachable while the full N-squared grid and the mux behind every column are still exercised.

// File: rtl/assoc_xbar_pkg.sv
package assoc_xbar_pkg;
  localparam int unsigned XB_PORTS  = 4;
  localparam int unsigned XB_ID_W   = 8;
  localparam int unsigned XB_DATA_W = 32;

  typedef enum logic [1:0] {
    COL_IDLE    = 2'd0,
    COL_DELIVER = 2'd1,
    COL_CLASH   = 2'd2
  } col_state_e;
endpackage

// File: rtl/assoc_xpoint.sv
module assoc_xpoint #(
  parameter int unsigned ID_W = 8
) (
  input  logic            row_valid,
  input  logic [ID_W-1:0] row_id,
  input  logic            col_valid,
  input  logic [ID_W-1:0] col_id,
  output logic            hit
);
  always_comb begin
    hit = row_valid && col_valid && (row_id == col_id);
  end
endmodule

// File: rtl/assoc_column.sv
module assoc_column
  import assoc_xbar_pkg::*;
#(
  parameter int unsigned N      = 4,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_valid,
  input  logic [N*ID_W-1:0]   wr_id,
  input  logic [N*DATA_W-1:0] wr_data,
  input  logic                rd_valid,
  input  logic [ID_W-1:0]     rd_id,
  output logic                out_valid,
  output logic [ID_W-1:0]     out_id,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_collide
);
  localparam logic [N-1:0] LSB_ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]      hit_vec;
  logic [DATA_W-1:0] sel_data;
  col_state_e        next_state;

  for (genvar r = 0; r < N; r++) begin : g_row
    assoc_xpoint #(.ID_W(ID_W)) u_xp (
      .row_valid (wr_valid[r]),
      .row_id    (wr_id[r*ID_W +: ID_W]),
      .col_valid (rd_valid),
      .col_id    (rd_id),
      .hit       (hit_vec[r])
    );
  end

  always_comb begin
    sel_data = '0;
    for (int r = 0; r < N; r++) begin
      if (hit_vec[r]) sel_data = sel_data | wr_data[r*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    if (hit_vec == '0)
      next_state = COL_IDLE;
    else if ((hit_vec & (hit_vec - LSB_ONE)) != '0)
      next_state = COL_CLASH;
    else
      next_state = COL_DELIVER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_id      <= '0;
      out_data    <= '0;
      out_collide <= 1'b0;
    end else begin
      out_valid   <= (next_state == COL_DELIVER);
      out_collide <= (next_state == COL_CLASH);
      out_id      <= (next_state == COL_DELIVER) ? rd_id : '0;
      out_data    <= (next_state == COL_DELIVER) ? sel_data : '0;
    end
  end

  // R4
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_collide) |-> $past(rd_valid));

  // R5
  clash_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_collide |-> !out_valid);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && out_id == '0));

  // R3
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_collide) |-> ($past(wr_valid) != '0));

  // R5
  clash_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_collide |-> ($countones($past(wr_valid)) >= 2));
endmodule

// File: rtl/assoc_xbar.sv
module assoc_xbar
  import assoc_xbar_pkg::*;
#(
  parameter int unsigned N      = XB_PORTS,
  parameter int unsigned ID_W   = XB_ID_W,
  parameter int unsigned DATA_W = XB_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr_valid,
  input  logic [N*ID_W-1:0]   wr_id,
  input  logic [N*DATA_W-1:0] wr_data,
  input  logic [N-1:0]        rd_valid,
  input  logic [N*ID_W-1:0]   rd_id,
  output logic [N-1:0]        out_valid,
  output logic [N*ID_W-1:0]   out_id,
  output logic [N*DATA_W-1:0] out_data,
  output logic [N-1:0]        out_collide
);
  for (genvar c = 0; c < N; c++) begin : g_col
    assoc_column #(.N(N), .ID_W(ID_W), .DATA_W(DATA_W)) u_col (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_id       (wr_id),
      .wr_data     (wr_data),
      .rd_valid    (rd_valid[c]),
      .rd_id       (rd_id[c*ID_W +: ID_W]),
      .out_valid   (out_valid[c]),
      .out_id      (out_id[c*ID_W +: ID_W]),
      .out_data    (out_data[c*DATA_W +: DATA_W]),
      .out_collide (out_collide[c])
    );

    // R1
    req_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[c] |-> (out_id[c*ID_W +: ID_W] == $past(rd_id[c*ID_W +: ID_W])));
  end
endmodule

// File: tb/assoc_xbar_bench.sv
`timescale 1ns/1ps
module assoc_xbar_bench;
  localparam int N = 4;
  localparam int IW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    wr_valid = '0;
  logic [N*IW-1:0] wr_id = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N-1:0]    rd_valid = '0;
  logic [N*IW-1:0] rd_id = '0;
  logic [N-1:0]    out_valid;
  logic [N*IW-1:0] out_id;
  logic [N*DW-1:0] out_data;
  logic [N-1:0]    out_collide;

  int checks = 0;
  int errors = 0;
  int exp_v[N];
  int exp_c[N];
  int exp_i[N];
  int exp_d[N];
  bit done = 0;

  always #2.5 clk = ~clk;

  assoc_xbar #(.N(N), .ID_W(IW), .DATA_W(DW)) u_assoc_xbar (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_id(wr_id), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_id(rd_id),
    .out_valid(out_valid), .out_id(out_id), .out_data(out_data),
    .out_collide(out_collide)
  );

  task automatic set_w(input int r, input bit v, input int id, input int d);
    wr_valid[r] = v;
    wr_id[r*IW +: IW] = id[IW-1:0];
    wr_data[r*DW +: DW] = d[DW-1:0];
  endtask

  task automatic set_r(input int c, input bit v, input int id);
    rd_valid[c] = v;
    rd_id[c*IW +: IW] = id[IW-1:0];
  endtask

  task automatic clear_all();
    wr_valid = '0; wr_id = '0; wr_data = '0;
    rd_valid = '0; rd_id = '0;
  endtask

  // behavioural reference: count matching writers per reader
  task automatic model();
    for (int c = 0; c < N; c++) begin
      int hits = 0;
      int dsel = 0;
      if (rd_valid[c]) begin
        for (int r = 0; r < N; r++) begin
          if (wr_valid[r] && wr_id[r*IW +: IW] == rd_id[c*IW +: IW]) begin
            hits++;
            dsel = int'(wr_data[r*DW +: DW]);
          end
        end
      end
      exp_v[c] = (hits == 1);
      exp_c[c] = (hits >= 2);
      exp_i[c] = (hits == 1) ? int'(rd_id[c*IW +: IW]) : 0;
      exp_d[c] = (hits == 1) ? dsel : 0;
    end
  endtask

  task automatic compare(input string tag);
    for (int c = 0; c < N; c++) begin
      int av = out_valid[c];
      int ac = out_collide[c];
      int ai = int'(out_id[c*IW +: IW]);
      int ad = int'(out_data[c*DW +: DW]);
      checks++;
      if (av != exp_v[c] || ac != exp_c[c] || ai != exp_i[c] || ad != exp_d[c]) begin
        errors++;
        $display("FAIL %s col %0d: v/col/id/data actual %0d/%0d/%0h/%0h expected %0d/%0d/%0h/%0h",
                 tag, c, av, ac, ai, ad, exp_v[c], exp_c[c], exp_i[c], exp_d[c]);
      end
    end
  endtask

  // inputs already set (after a negedge); model at the edge, check at the next negedge
  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin
      exp_v[c] = 0; exp_c[c] = 0; exp_i[c] = 0; exp_d[c] = 0;
    end
    // R8: reset values while held, then after release
    repeat (3) @(negedge clk);
    compare("R8 in reset");
    rst_n = 1'b1;
    step("R8 after release");

    // R1: single match, row 2 to column 0
    clear_all();
    set_w(2, 1, 5, 8'hA7); set_r(0, 1, 5);
    step("R1 single");
    // R1: permutation, every row to a different column
    clear_all();
    for (int r = 0; r < N; r++) begin
      set_w(r, 1, r + 8, 8'h10 + r);
      set_r((r + 1) % N, 1, r + 8);
    end
    step("R1 permute");

    // R2: requests that match nothing
    clear_all();
    set_w(0, 1, 3, 8'h33); set_r(1, 1, 4); set_r(2, 1, 9);
    step("R2 nomatch");

    // R3: invalid row with matching id ignored
    clear_all();
    set_w(1, 0, 6, 8'h66); set_r(3, 1, 6);
    step("R3 invalid row");
    // R3: invalid row does not turn a single match into a collision
    clear_all();
    set_w(0, 1, 7, 8'h71); set_w(3, 0, 7, 8'h7F); set_r(2, 1, 7);
    step("R3 no extra hit");

    // R4: invalid column ignored even when rows match
    clear_all();
    set_w(0, 1, 2, 8'h22); set_w(1, 1, 2, 8'h23); set_r(0, 0, 2);
    step("R4 invalid col");

    // R5: two rows, then all four rows on one column
    clear_all();
    set_w(0, 1, 1, 8'h01); set_w(2, 1, 1, 8'h02); set_r(1, 1, 1);
    step("R5 clash2");
    clear_all();
    for (int r = 0; r < N; r++) set_w(r, 1, 12, 8'hC0 + r);
    set_r(3, 1, 12); set_r(0, 1, 11);
    step("R5 clash4");

    // R6: one packet to all readers
    clear_all();
    set_w(1, 1, 14, 8'h5A);
    for (int c = 0; c < N; c++) set_r(c, 1, 14);
    step("R6 multicast");

    // R7: write first, read one cycle later: nothing delivered
    clear_all();
    set_w(2, 1, 10, 8'hBE);
    step("R7 write early");
    clear_all();
    set_r(0, 1, 10);
    step("R7 read late");

    // R9 + R1: back to back held match, then idle
    clear_all();
    set_w(3, 1, 4, 8'h44); set_r(2, 1, 4);
    step("R1 held a");
    step("R1 held b");
    clear_all();
    step("R9 idle zero");

    // mixed random traffic from a small id range
    for (int k = 0; k < 400; k++) begin
      for (int r = 0; r < N; r++) set_w(r, $urandom_range(0, 3) != 0, $urandom_range(0, 3), $urandom_range(0, 255));
      for (int c = 0; c < N; c++) set_r(c, $urandom_range(0, 3) != 0, $urandom_range(0, 3));
      step("R1/R5 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule